// File: doc/BRIEF.md
# Rank-Ordered Insert Queue

This block keeps up to `DEPTH` entries in one logical queue, ordered by ascending rank, where the rank is the entry's scheduled departure position. An arriving entry, carrying a rank, a flow identifier and a payload, may land anywhere in the queue. Service always removes the head, which is the entry with the lowest rank.

The queue stands in for a set of per-flow FIFOs drained by a weighted scheduler. The scheduler computes a rank for each arrival, and the queue turns those ranks into a single departure order.

Storage is a sorted shift-register array. In each cycle every slot compares its rank with the incoming rank in parallel. Slots from the insertion point onward move one place toward the tail, and the new entry drops into the slot that opens. A push and a pop may be issued in the same cycle.

Top module: `pifo_queue`

## Requirements
- R1: After reset `empty_o` is 1, and `full_o`, `overflow_o` and `pop_vld_o` are 0.
- R2: When `pop_i` is high and the queue holds entries, `pop_vld_o` is 1 in the same cycle. `pop_rank_o`, `pop_flow_o` and `pop_data_o` then carry the stored entry with the lowest rank, and that entry leaves at the next clock edge. Entries therefore leave in ascending rank order.
- R3: Entries with equal rank leave in arrival order. A flow whose ranks never decrease is therefore never reordered.
- R4: A pushed entry whose rank is below every stored rank becomes the new head, whatever the number of stored entries.
- R5: With a push and a pop in the same cycle on a non-empty queue, the pop returns the head as it stood before the insert, even when the new rank is lower. The pushed entry is stored.
- R6: With a push and a pop in the same cycle on an empty queue, the pushed entry is returned at once on the pop outputs, and the queue stays empty.
- R7: `empty_o` is 1 exactly when no entry is stored. `full_o` is 1 exactly when `DEPTH` entries are stored.
- R8: A push while full, with no pop in the same cycle, is dropped and leaves the contents unchanged. `overflow_o` is then 1 for exactly the following cycle.
- R9: A push together with a pop while full is accepted. The queue stays full and raises no overflow.
- R10: A pop on an empty queue with no push gives `pop_vld_o` = 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Insert an entry this cycle |
| push_rank_i | input | RANK_W | Rank of the arriving entry |
| push_flow_i | input | FLOW_W | Flow identifier of the arriving entry |
| push_data_i | input | DATA_W | Payload of the arriving entry |
| pop_i | input | 1 | Remove the head this cycle |
| pop_vld_o | output | 1 | Pop outputs carry an entry |
| pop_rank_o | output | RANK_W | Rank of the popped entry |
| pop_flow_o | output | FLOW_W | Flow of the popped entry |
| pop_data_o | output | DATA_W | Payload of the popped entry |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |
| overflow_o | output | 1 | One-cycle pulse after a dropped push |

## Verification
The queue is first filled with ranks that arrive out of order and contain duplicates. This separates a correct sorted insert from plain FIFO order and shows whether ties keep arrival order. A rank lower than the head is then pushed together with a pop on a full queue, which shows whether the pop takes the pre-insert head and whether the insert lands at slot zero. Fixed runs cover the edge cases: a pop on an empty queue, a push with a pop on an empty queue, and a push while full. A long pseudo-random phase mixes push-heavy and pop-heavy stretches over a narrow range of ranks. It exercises every insertion position, every occupancy and back-to-back simultaneous operations against a reference model of the ordering rule.

// File: rtl/pifo_pkg.sv
package pifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BOTH = 2'd3
  } pifo_op_e;
endpackage

// File: rtl/pifo_ctrl.sv
module pifo_ctrl
  import pifo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  logic     pop_i,
  input  logic     head_vld_i,
  input  logic     tail_vld_i,
  output pifo_op_e op_o,
  output logic     bypass_o,
  output logic     full_o,
  output logic     empty_o,
  output logic     overflow_o
);
  logic reject;

  assign empty_o  = ~head_vld_i;
  assign full_o   = tail_vld_i;
  assign bypass_o = push_i & pop_i & empty_o;
  assign reject   = push_i & ~pop_i & full_o;

  always_comb begin
    op_o = OP_IDLE;
    if (pop_i && !empty_o) op_o = push_i ? OP_BOTH : OP_POP;
    else if (push_i && !pop_i && !full_o) op_o = OP_PUSH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overflow_o <= 1'b0;
    else         overflow_o <= reject;
  end

  p_ovf_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> overflow_o);
  p_ovf_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !pop_i && full_o) |=> !overflow_o);
  p_no_op_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i) |-> (op_o == OP_IDLE));
endmodule

// File: rtl/pifo_rank_cmp.sv
module pifo_rank_cmp #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 8
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][RANK_W-1:0] rank_i,
  input  logic [RANK_W-1:0]            in_rank_i,
  output logic [DEPTH:0]               after_o
);
  // after_o[i]: slot i lies at or beyond the insert point (strictly greater rank or empty)
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign after_o[i] = ~vld_i[i] | (rank_i[i] > in_rank_i);
  end
  assign after_o[DEPTH] = 1'b1;
endmodule

// File: rtl/pifo_cell.sv
module pifo_cell
  import pifo_pkg::*;
#(
  parameter int ENT_W   = 28,
  parameter bit IS_HEAD = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pifo_op_e         op_i,
  input  logic             after_prev_i,
  input  logic             after_self_i,
  input  logic             after_next_i,
  input  logic [ENT_W-1:0] prev_q_i,
  input  logic [ENT_W-1:0] next_q_i,
  input  logic [ENT_W-1:0] new_i,
  output logic [ENT_W-1:0] q_o
);
  logic [ENT_W-1:0] d;
  logic             keep_self;

  // head slot is vacated by the pop, so it never keeps its own entry
  assign keep_self = after_self_i & ~IS_HEAD;

  always_comb begin
    unique case (op_i)
      OP_PUSH: d = after_self_i ? (after_prev_i ? prev_q_i : new_i) : q_o;
      OP_POP:  d = next_q_i;
      OP_BOTH: d = after_next_i ? (keep_self ? q_o : new_i) : next_q_i;
      default: d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/pifo_queue.sv
module pifo_queue
  import pifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 8,
  parameter int FLOW_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [RANK_W-1:0] push_rank_i,
  input  logic [FLOW_W-1:0] push_flow_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              pop_vld_o,
  output logic [RANK_W-1:0] pop_rank_o,
  output logic [FLOW_W-1:0] pop_flow_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o
);
  localparam int PAY_W = RANK_W + FLOW_W + DATA_W;
  localparam int ENT_W = 1 + PAY_W;
  localparam int VLD_B = ENT_W - 1;

  logic [DEPTH-1:0][ENT_W-1:0]  cells_q;
  logic [DEPTH-1:0][ENT_W-1:0]  prev_w, next_w;
  logic [DEPTH-1:0]             vld_w, after_prev_w;
  logic [DEPTH-1:0][RANK_W-1:0] rank_w;
  logic [DEPTH:0]               after_w;
  logic [ENT_W-1:0]             new_w;
  logic [PAY_W-1:0]             out_w;
  pifo_op_e                     op;
  logic                         bypass;

  assign new_w = {1'b1, push_rank_i, push_flow_i, push_data_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign vld_w[i]  = cells_q[i][VLD_B];
    assign rank_w[i] = cells_q[i][VLD_B-1 -: RANK_W];
    if (i == 0) begin : g_first
      assign prev_w[i]       = '0;
      assign after_prev_w[i] = 1'b0;
    end else begin : g_mid
      assign prev_w[i]       = cells_q[i-1];
      assign after_prev_w[i] = after_w[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign next_w[i] = '0;
    end else begin : g_inner
      assign next_w[i] = cells_q[i+1];
    end

    pifo_cell #(.ENT_W(ENT_W), .IS_HEAD(i == 0)) u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .op_i         (op),
      .after_prev_i (after_prev_w[i]),
      .after_self_i (after_w[i]),
      .after_next_i (after_w[i+1]),
      .prev_q_i     (prev_w[i]),
      .next_q_i     (next_w[i]),
      .new_i        (new_w),
      .q_o          (cells_q[i])
    );
  end

  pifo_rank_cmp #(.DEPTH(DEPTH), .RANK_W(RANK_W)) u_cmp (
    .vld_i     (vld_w),
    .rank_i    (rank_w),
    .in_rank_i (push_rank_i),
    .after_o   (after_w)
  );

  pifo_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .head_vld_i (vld_w[0]),
    .tail_vld_i (vld_w[DEPTH-1]),
    .op_o       (op),
    .bypass_o   (bypass),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .overflow_o (overflow_o)
  );

  assign out_w      = bypass ? new_w[PAY_W-1:0] : cells_q[0][PAY_W-1:0];
  assign pop_vld_o  = pop_i & (vld_w[0] | push_i);
  assign pop_rank_o = out_w[PAY_W-1 -: RANK_W];
  assign pop_flow_o = out_w[DATA_W +: FLOW_W];
  assign pop_data_o = out_w[DATA_W-1:0];

  for (genvar i = 0; i < DEPTH-1; i++) begin : g_chk
    p_sorted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_w[i+1] |-> (rank_w[i] <= rank_w[i+1]));
    p_packed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_w[i+1] |-> vld_w[i]);
  end
  p_reject_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> $stable(cells_q));
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |-> !pop_vld_o);
  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i && empty_o) |=> empty_o);
  p_full_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i && full_o) |=> full_o);
  p_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/sim_pifo_queue.sv
`timescale 1ns/1ps
module sim_pifo_queue;
  localparam int DEPTH = 8;
  localparam int PW    = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0;
  logic [7:0]  push_rank_i = '0;
  logic [2:0]  push_flow_i = '0;
  logic [15:0] push_data_i = '0;
  logic        pop_vld_o, full_o, empty_o, overflow_o;
  logic [7:0]  pop_rank_o;
  logic [2:0]  pop_flow_o;
  logic [15:0] pop_data_o;

  int total = 0, bad = 0;
  bit finished = 0;
  bit exp_ovf = 0;
  logic [PW-1:0] mq[$];

  always #4 clk = ~clk;

  pifo_queue u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .push_i(push_i), .push_rank_i(push_rank_i), .push_flow_i(push_flow_i),
    .push_data_i(push_data_i), .pop_i(pop_i),
    .pop_vld_o(pop_vld_o), .pop_rank_o(pop_rank_o), .pop_flow_o(pop_flow_o),
    .pop_data_o(pop_data_o), .full_o(full_o), .empty_o(empty_o),
    .overflow_o(overflow_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_insert(input logic [PW-1:0] w);
    int pos = mq.size();
    for (int k = 0; k < mq.size(); k++)
      if (mq[k][PW-1 -: 8] > w[PW-1 -: 8]) begin pos = k; break; end
    mq.insert(pos, w);
  endtask

  // driver + monitor: drive on falling edge, compare pop outputs and flags vs scoreboard
  task automatic step(input bit psh, input bit pp, input logic [7:0] rk,
                      input logic [2:0] fl, input logic [15:0] dt, input string tag);
    logic [PW-1:0] nw, exp_w;
    bit exp_vld;
    @(negedge clk);
    push_i = psh; pop_i = pp;
    push_rank_i = rk; push_flow_i = fl; push_data_i = dt;
    #2;
    nw = {rk, fl, dt};
    check(overflow_o == exp_ovf, "R8", 32'(overflow_o), 32'(exp_ovf));
    check(empty_o == (mq.size() == 0), "R7", 32'(empty_o), 32'(mq.size() == 0));
    check(full_o == (mq.size() == DEPTH), "R7", 32'(full_o), 32'(mq.size() == DEPTH));
    if (pp) begin
      exp_vld = (mq.size() != 0) || psh;
      exp_w   = (mq.size() != 0) ? mq[0] : nw;
      check(pop_vld_o == exp_vld, tag, 32'(pop_vld_o), 32'(exp_vld));
      if (exp_vld)
        check({pop_rank_o, pop_flow_o, pop_data_o} == exp_w, tag,
              32'({pop_rank_o, pop_flow_o, pop_data_o}), 32'(exp_w));
    end
    exp_ovf = psh && !pp && (mq.size() == DEPTH);
    if (pp && mq.size() != 0) begin
      void'(mq.pop_front());
      if (psh) model_insert(nw);
    end else if (psh && !pp && mq.size() < DEPTH) begin
      model_insert(nw);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(empty_o == 1'b1, "R1", 32'(empty_o), 32'd1);
    check(full_o == 1'b0, "R1", 32'(full_o), 32'd0);
    check(overflow_o == 1'b0, "R1", 32'(overflow_o), 32'd0);
    check(pop_vld_o == 1'b0, "R1", 32'(pop_vld_o), 32'd0);
    rst_n = 1'b1;

    step(0, 1, 8'd0, 3'd0, 16'h0, "R10");       // R10 pop on empty
    step(1, 1, 8'd9, 3'd4, 16'hB0B0, "R6");     // R6 bypass
    step(0, 0, 8'd0, 3'd0, 16'h0, "R6");        // stays empty (checked via R7 flag)

    // out-of-order ranks with ties: R2, R3
    step(1, 0, 8'd50, 3'd1, 16'h0001, "R2");
    step(1, 0, 8'd10, 3'd1, 16'h0002, "R2");
    step(1, 0, 8'd30, 3'd2, 16'h0003, "R2");
    step(1, 0, 8'd10, 3'd2, 16'h0004, "R3");
    step(1, 0, 8'd70, 3'd3, 16'h0005, "R2");
    step(1, 0, 8'd30, 3'd1, 16'h0006, "R3");
    step(1, 0, 8'd20, 3'd4, 16'h0007, "R2");
    step(1, 0, 8'd5,  3'd5, 16'h0008, "R4");    // R4 lands at head
    step(1, 0, 8'd1,  3'd6, 16'h0009, "R8");    // full, dropped
    step(0, 0, 8'd0,  3'd0, 16'h0,    "R8");    // overflow pulse sampled here
    step(1, 1, 8'd3,  3'd7, 16'h000A, "R5");    // R5 and R9: pop old head 5
    step(1, 1, 8'd255, 3'd0, 16'h000B, "R9");   // R9 push+pop at tail
    for (int k = 0; k < DEPTH + 1; k++) step(0, 1, 8'd0, 3'd0, 16'h0, "R2");
    step(0, 1, 8'd0, 3'd0, 16'h0, "R10");

    // R4: low rank into a partly filled queue becomes head
    step(1, 0, 8'd40, 3'd1, 16'h0100, "R4");
    step(1, 0, 8'd41, 3'd1, 16'h0101, "R4");
    step(1, 0, 8'd2,  3'd2, 16'h0102, "R4");
    step(0, 1, 8'd0,  3'd0, 16'h0,    "R4");

    // mixed pseudo-random traffic, R3 ties from a narrow rank range
    for (int n = 0; n < 600; n++) begin
      bit psh, pp;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((n / 100) % 2 == 0) begin psh = lfsr[0] | lfsr[1]; pp = lfsr[2] & lfsr[3]; end
      else                    begin psh = lfsr[0] & lfsr[1]; pp = lfsr[2] | lfsr[3]; end
      step(psh, pp, {4'd0, lfsr[7:4]}, lfsr[10:8], 16'(n), "R3");
    end
    while (mq.size() != 0) step(0, 1, 8'd0, 3'd0, 16'h0, "R2");
    step(0, 0, 8'd0, 3'd0, 16'h0, "R7");
    finish_run();
  end
endmodule